// File: doc/BRIEF.md
# Frame Timing Status and Vertical-Blank Interrupt Flags

This block holds the three frame-timing flags of a raster video unit: vertical blank, sprite-0 hit and sprite overflow. It drives the host-visible status byte and an active-low interrupt line from them. The frame position does not come from a counter inside the block. The raster timing logic supplies the current dot and scanline each cycle. The block decodes from that position the exact cycle on which the vertical-blank flag is raised and the cycle on which all three flags are dropped.

The host reads the status byte through a one-cycle read strobe. The byte returned on that cycle holds the flag values from before the read takes effect. The same read clears the vertical-blank flag and produces a one-cycle pulse that resets the shared two-write scroll/address toggle. The renderer raises the sprite flags through single-cycle set pulses. The five low bits of the status byte are not stored here: they echo the last byte the host wrote to any register, which arrives on an input.

All pins are plain control or status signals. No stream passes through the block, so it has no valid/ready handshake and applies no back-pressure. The default frame is 341 dots by 262 scanlines. Vertical blank starts on scanline 241, and scanline 261 is the pre-render line. Flag events fall on dot 1.

Top module: `frame_status_flags`

## Requirements
- R1: After reset all three flags read 0. The vertical-blank flag (status bit 7) is set by the clock edge that ends the cycle where dot = 1 and line = 241. It reads 1 from the following cycle onward.
- R2: All three flags are cleared by the edge that ends the cycle where dot = 1 and line = 261. Apart from R1 and R3, no other dot/line value changes the vertical-blank flag.
- R3: A status read (stat_rd high for one cycle) returns the pre-read flag values on that same cycle. The vertical-blank flag reads 0 from the next cycle.
- R4: Sprite-0 hit (bit 6) and sprite overflow (bit 5) are set by their pulses and then hold. Status reads do not clear them. Only the R2 clear drops them, and that clear wins over a set pulse in the same cycle.
- R5: status_byte[4:0] always equals bus_latch[4:0].
- R6: A status read in the cycle that matches the R1 set position returns 0 in bit 7, and the flag stays 0 after that edge. That frame's vertical blank is lost.
- R7: nmi_n is 0 exactly when the vertical-blank flag is 1 and nmi_en is 1. It follows nmi_en in the same cycle.
- R8: Driving nmi_en from 0 to 1 while the vertical-blank flag is still 1 pulls nmi_n low again.
- R9: toggle_clr is high for exactly the one cycle after each cycle in which stat_rd is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dot | input | 9 | Current dot within the scanline |
| line | input | 9 | Current scanline |
| stat_rd | input | 1 | One-cycle host read of the status byte |
| hit_set | input | 1 | Renderer pulse: sprite-0 hit detected |
| ovf_set | input | 1 | Renderer pulse: sprite overflow detected |
| nmi_en | input | 1 | Interrupt enable control bit |
| bus_latch | input | 8 | Last byte written to any register |
| status_byte | output | 8 | {vblank, hit, overflow, bus_latch[4:0]} |
| nmi_n | output | 1 | Vertical-blank interrupt, active low |
| toggle_clr | output | 1 | Pulse that resets the shared write toggle |

## Verification
The hardest case to reach is the read that lands on the very cycle the vertical-blank flag would be raised. The bench drives dot and line directly, so it can put a read on dot 1 of line 241. It samples the byte before that edge and checks the flag again after the edge and one dot later. The bench also sweeps every position of a whole frame with the interrupt enabled, which shows that only the two decoded positions ever move the flag. A second interrupt edge is produced by toggling the enable while the flag is held.

// File: rtl/frame_status_pkg.sv
package frame_status_pkg;
  localparam int FLAG_COUNT = 3;
  localparam int IDX_OVF    = 0;
  localparam int IDX_HIT    = 1;
  localparam int IDX_VBL    = 2;

  typedef struct packed {
    logic vbl;
    logic hit;
    logic ovf;
  } flags_t;

  function automatic logic [7:0] pack_status(input flags_t f, input logic [7:0] latch);
    return {f.vbl, f.hit, f.ovf, latch[4:0]};
  endfunction
endpackage

// File: rtl/fsf_pos_decode.sv
module fsf_pos_decode #(
  parameter int DOT_W     = 9,
  parameter int LINE_W    = 9,
  parameter int DOTS      = 341,
  parameter int LINES     = 262,
  parameter int VBL_LINE  = 241,
  parameter int EVENT_DOT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DOT_W-1:0]  dot,
  input  logic [LINE_W-1:0] line,
  output logic              vbl_start,
  output logic              frame_clr
);
  localparam int PRE_LINE = LINES - 1;
  localparam logic [DOT_W-1:0]  EV_DOT_V = DOT_W'(EVENT_DOT);
  localparam logic [LINE_W-1:0] VBL_V    = LINE_W'(VBL_LINE);
  localparam logic [LINE_W-1:0] PRE_V    = LINE_W'(PRE_LINE);

  logic on_event_dot;

  always_comb begin
    on_event_dot = (dot == EV_DOT_V);
    vbl_start    = on_event_dot && (line == VBL_V);
    frame_clr    = on_event_dot && (line == PRE_V);
  end

  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(dot) < DOTS) && (int'(line) < LINES)); // R1
endmodule

// File: rtl/fsf_flag_cell.sv
module fsf_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= 1'b0;
    else if (clr_i) q <= 1'b0;
    else if (set_i) q <= 1'b1;
  end

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !q); // R4
  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i) |=> q); // R4
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(q)); // R4
endmodule

// File: rtl/fsf_nmi_drive.sv
module fsf_nmi_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic vbl,
  input  logic nmi_en,
  input  logic stat_rd,
  output logic nmi_n,
  output logic toggle_clr
);
  always_comb nmi_n = !(vbl && nmi_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) toggle_clr <= 1'b0;
    else        toggle_clr <= stat_rd;
  end

  AST_TOGGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> toggle_clr); // R9
  AST_TOGGLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> !toggle_clr); // R9
  AST_NMI_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(nmi_en) && vbl) |-> !nmi_n); // R8
endmodule

// File: rtl/frame_status_flags.sv
module frame_status_flags
  import frame_status_pkg::*;
#(
  parameter int DOT_W     = 9,
  parameter int LINE_W    = 9,
  parameter int DOTS      = 341,
  parameter int LINES     = 262,
  parameter int VBL_LINE  = 241,
  parameter int EVENT_DOT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DOT_W-1:0]  dot,
  input  logic [LINE_W-1:0] line,
  input  logic              stat_rd,
  input  logic              hit_set,
  input  logic              ovf_set,
  input  logic              nmi_en,
  input  logic [7:0]        bus_latch,
  output logic [7:0]        status_byte,
  output logic              nmi_n,
  output logic              toggle_clr
);
  logic vbl_start, frame_clr;
  logic [FLAG_COUNT-1:0] set_v, clr_v, q_v;
  flags_t flags;

  fsf_pos_decode #(
    .DOT_W(DOT_W), .LINE_W(LINE_W), .DOTS(DOTS), .LINES(LINES),
    .VBL_LINE(VBL_LINE), .EVENT_DOT(EVENT_DOT)
  ) u_pos (
    .clk(clk), .rst_n(rst_n), .dot(dot), .line(line),
    .vbl_start(vbl_start), .frame_clr(frame_clr)
  );

  // The read takes priority over the start of blank: the flag is never raised.
  always_comb begin
    set_v = '0;
    clr_v = '0;
    set_v[IDX_VBL] = vbl_start && !stat_rd;
    clr_v[IDX_VBL] = frame_clr || stat_rd;
    set_v[IDX_HIT] = hit_set;
    clr_v[IDX_HIT] = frame_clr;
    set_v[IDX_OVF] = ovf_set;
    clr_v[IDX_OVF] = frame_clr;
  end

  for (genvar i = 0; i < FLAG_COUNT; i++) begin : g_flag
    fsf_flag_cell u_cell (
      .clk(clk), .rst_n(rst_n), .set_i(set_v[i]), .clr_i(clr_v[i]), .q(q_v[i])
    );
  end

  always_comb begin
    flags       = q_v;
    status_byte = pack_status(flags, bus_latch);
  end

  fsf_nmi_drive u_nmi (
    .clk(clk), .rst_n(rst_n), .vbl(flags.vbl), .nmi_en(nmi_en),
    .stat_rd(stat_rd), .nmi_n(nmi_n), .toggle_clr(toggle_clr)
  );

  AST_VBL_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (vbl_start && !stat_rd) |=> status_byte[7]); // R1
  AST_PRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_clr |=> (status_byte[7:5] == 3'b000)); // R2
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> !status_byte[7]); // R3
  AST_RACE_HIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (vbl_start && stat_rd) |-> !status_byte[7]); // R6
  AST_NMI_NEEDS_VBL: assert property (@(posedge clk) disable iff (!rst_n)
    !nmi_n |-> (status_byte[7] && nmi_en)); // R7
endmodule

// File: tb/tb_frame_status_flags.sv
`timescale 1ns/1ps
module tb_frame_status_flags;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, stat_rd, hit_set, ovf_set, nmi_en;
  logic [8:0] dot, line;
  logic [7:0] bus_latch, status_byte;
  logic nmi_n, toggle_clr;

  frame_status_flags dut (
    .clk(clk), .rst_n(rst_n), .dot(dot), .line(line), .stat_rd(stat_rd),
    .hit_set(hit_set), .ovf_set(ovf_set), .nmi_en(nmi_en), .bus_latch(bus_latch),
    .status_byte(status_byte), .nmi_n(nmi_n), .toggle_clr(toggle_clr)
  );

  int errs = 0, checks = 0;
  bit done = 0;
  bit mv = 0, mh = 0, mo = 0;
  logic [7:0] pre;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int l, input int d, input bit rd, input bit hs, input bit os);
    bit pv, pc;
    @(negedge clk);
    line = 9'(l); dot = 9'(d); stat_rd = rd; hit_set = hs; ovf_set = os;
    #1 pre = status_byte;
    pv = (l == 241) && (d == 1);
    pc = (l == 261) && (d == 1);
    mv = (pc || rd) ? 1'b0 : (pv ? 1'b1 : mv);
    mh = pc ? 1'b0 : (hs ? 1'b1 : mh);
    mo = pc ? 1'b0 : (os ? 1'b1 : mo);
    @(posedge clk);
    #1;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; stat_rd = 0; hit_set = 0; ovf_set = 0; nmi_en = 1;
    dot = 0; line = 0; bus_latch = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 reset flags", int'(status_byte[7:5]), 0);
    chk("R7 reset nmi_n", int'(nmi_n), 1);
    chk("R9 reset toggle", int'(toggle_clr), 0);

    // R1 R2 R7: full frame sweep, flag moves only at the two decoded positions
    for (int l = 0; l < 262; l++) begin
      for (int d = 0; d < 341; d++) begin
        step(l, d, 0, 0, 0);
        chk("R1/R2 sweep vblank", int'(status_byte[7]), int'(mv));
        chk("R7 sweep nmi_n", int'(nmi_n), int'(!mv));
      end
    end

    // R3 R9: read returns the set flag and clears it
    step(241, 1, 0, 0, 0);
    chk("R1 set", int'(status_byte[7]), 1);
    step(250, 5, 1, 0, 0);
    chk("R3 read value", int'(pre[7]), 1);
    chk("R3 cleared", int'(status_byte[7]), 0);
    chk("R9 toggle high", int'(toggle_clr), 1);
    chk("R7 nmi released", int'(nmi_n), 1);
    step(250, 6, 0, 0, 0);
    chk("R9 toggle one cycle", int'(toggle_clr), 0);

    // R6: read on the exact set dot
    step(241, 0, 0, 0, 0);
    step(241, 1, 1, 0, 0);
    chk("R6 read value", int'(pre[7]), 0);
    chk("R6 flag stays 0", int'(status_byte[7]), 0);
    step(241, 2, 0, 0, 0);
    chk("R6 later dot", int'(status_byte[7]), 0);
    chk("R6 no nmi", int'(nmi_n), 1);

    // R1: read one dot earlier does not hide the flag
    step(241, 0, 1, 0, 0);
    chk("R3 early read", int'(pre[7]), 0);
    step(241, 1, 0, 0, 0);
    chk("R1 set after early read", int'(status_byte[7]), 1);

    // R7 R8: enable toggling while flag held
    nmi_en = 0; #1;
    chk("R7 disabled", int'(nmi_n), 1);
    nmi_en = 1; #1;
    chk("R8 re-assert", int'(nmi_n), 0);
    nmi_en = 0; #1;
    chk("R7 disabled again", int'(nmi_n), 1);
    nmi_en = 1; #1;
    chk("R8 re-assert again", int'(nmi_n), 0);

    step(261, 1, 0, 0, 0);
    chk("R2 pre-render clear", int'(status_byte[7:5]), 0);
    chk("R7 nmi after clear", int'(nmi_n), 1);

    // R4: sprite flags
    step(10, 3, 0, 1, 0);
    chk("R4 hit set", int'(status_byte[7:5]), 3'b010);
    step(100, 5, 1, 0, 0);
    chk("R4 hit survives read", int'(status_byte[6]), 1);
    step(261, 0, 0, 0, 0);
    chk("R4 hit holds", int'(status_byte[6]), 1);
    step(12, 7, 0, 0, 1);
    chk("R4 ovf set", int'(status_byte[7:5]), 3'b011);
    step(261, 1, 0, 1, 1);
    chk("R4 clear wins", int'(status_byte[7:5]), 0);
    step(261, 2, 0, 0, 0);
    chk("R4 stays clear", int'(status_byte[7:5]), {mv, mh, mo});

    // R5: low bits echo the latch for all values
    step(5, 9, 0, 1, 0);
    for (int v = 0; v < 256; v++) begin
      bus_latch = 8'(v); #1;
      chk("R5 low bits", int'(status_byte), int'({mv, mh, mo, bus_latch[4:0]}));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule